// File: doc/BRIEF.md
# Dual Warp Issue Scheduler

This block is the issue front end of one multiprocessor. It holds the lane-enable state of a set of resident warps, each a bundle of 32 threads that run the same instruction in lockstep. Every cycle, two independent schedulers each choose at most one warp with a pending instruction and send it to one of three execution groups. Scheduler 0 serves the even-numbered warps and scheduler 1 serves the odd-numbered ones. The groups are a 16-lane arithmetic core group, a 16-lane load/store group and a 4-lane special-function group. A whole warp passes through a narrow group in several beats, so each group stays occupied for a number of cycles after every issue.

The instruction source presents one candidate instruction per warp. Each candidate carries a unit code, an operation code and a 32-bit condition mask. The block acknowledges the chosen warps combinationally in the same cycle. When a warp's threads split on a branch, the block runs the taken lanes first and saves the other lanes on a small per-warp stack. Reconvergence operations bring the saved lanes back later. Instruction decode and the datapaths are outside this block.

Top module: `warp_issue_dual`

## Requirements
- R1: After reset, no group is busy, no warp is acknowledged, and every warp's active lane mask is all ones.
- R2: Scheduler 0 considers only even warps and scheduler 1 only odd warps. Each issues at most one warp per cycle, and only a warp whose `inst_valid` is high is acknowledged on `issue_ack` in that same cycle.
- R3: An issue to the core group (unit 0) or the load/store group (unit 1) keeps that group busy for 2 cycles. An issue to the special-function group (unit 2) keeps it busy for 8 cycles. `grp_busy` is high from the cycle after the issue until the group can accept again, and a busy group receives no issue.
- R4: Each scheduler uses round-robin priority among its ready warps, starting its search at the warp after the one it last issued. After reset, the search starts at its lowest warp.
- R5: If the warps picked by both schedulers name the same group in the same cycle, scheduler 0 issues and scheduler 1 issues nothing that cycle, even if another of its warps could use a different group.
- R6: An issue raises `grp_issue[u]` for unit code u and presents the warp index on `grp_warp[u]` and that warp's active mask at issue time on `grp_mask[u]`.
- R7: Operation code 1 (branch) with condition c on active mask a is divergent when both a&c and a&~c are nonzero. In that case a&~c is pushed on the warp's stack, and a&c becomes the active mask for the following issues. The stack holds 4 entries, and a divergent branch on a full stack leaves the state unchanged.
- R8: A branch whose condition is uniform over the active lanes (a&c zero or a&~c zero) pushes nothing and leaves the active mask unchanged.
- R9: Operation code 2 (reconverge) pops the top stack entry into the active mask. If the stack is empty, it sets the active mask to all ones.
- R10: Operation code 3 (exit) clears the lanes set in c from the active mask. A warp whose active mask is all zeros is never issued.
- R11: Unit code 3 is reserved, and an instruction carrying it is never issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| inst_valid | input | NUM_WARPS | Per-warp candidate instruction present |
| inst_unit | input | NUM_WARPS x 2 | Per-warp unit code: 0 core, 1 load/store, 2 special function, 3 reserved |
| inst_op | input | NUM_WARPS x 2 | Per-warp operation: 0 plain, 1 branch, 2 reconverge, 3 exit |
| inst_cond | input | NUM_WARPS x THREADS | Per-warp condition mask (branch taken lanes, or lanes to exit) |
| issue_ack | output | NUM_WARPS | Warp issued this cycle |
| grp_issue | output | 3 | Issue strobe per group, indexed by unit code |
| grp_warp | output | 3 x log2(NUM_WARPS) | Warp index of the issue on each group |
| grp_mask | output | 3 x THREADS | Active lane mask of the issue on each group |
| grp_busy | output | 3 | Group still occupied by an earlier issue |

## Verification
An issue is a combinational function of registered state and the current inputs. Its strobe, warp index, mask and acknowledge are therefore due in the same cycle the candidate is driven. The bench drives inputs on the falling edge and compares a quarter period later, before the next rising edge. `grp_busy` follows the issue by one edge. A narrow group frees 2 cycles (16-wide) or 8 cycles (4-wide) after its issue, so the bench holds waiting candidates and expects the issue on exactly that cycle. A mask change from a branch, reconverge or exit only shows up on the warp's next issue. The scoreboard predicts that issue from its own lane-stack model, tagged with the cycle in which it must appear.

// File: rtl/dws_pkg.sv
package dws_pkg;

  typedef enum logic [1:0] {
    GRP_CORE = 2'd0,
    GRP_LDST = 2'd1,
    GRP_SFU  = 2'd2,
    GRP_RSVD = 2'd3
  } grp_e;

  typedef enum logic [1:0] {
    OP_PLAIN  = 2'd0,
    OP_BRANCH = 2'd1,
    OP_RECONV = 2'd2,
    OP_EXIT   = 2'd3
  } op_e;

  // beats needed to stream a whole warp through a group of the given width
  function automatic int occupancy(input int threads, input int lanes);
    return (threads + lanes - 1) / lanes;
  endfunction

  // slot examined at search step k after the last issued slot
  function automatic int rr_slot(input int last, input int k, input int n);
    return (last + k) % n;
  endfunction

  // a group can take an issue when its unit code is real and it is idle
  function automatic logic unit_free(input logic [2:0] busy, input logic [1:0] unit);
    case (unit)
      2'd0:    return !busy[0];
      2'd1:    return !busy[1];
      2'd2:    return !busy[2];
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/dws_grp_timer.sv
module dws_grp_timer #(
  parameter int THREADS = 32,
  parameter int LANES   = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int OCC = dws_pkg::occupancy(THREADS, LANES);
  localparam int CW  = $clog2(OCC + 1);

  logic [CW-1:0] beats_left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                beats_left <= '0;
    else if (start)            beats_left <= CW'(OCC - 1);
    else if (beats_left != '0) beats_left <= beats_left - 1'b1;
  end

  assign busy = (beats_left != '0);

  p_start_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);

  if (OCC > 1) begin : g_multi
    p_busy_after_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy);
  end

endmodule

// File: rtl/dws_rr_pick.sv
module dws_rr_pick #(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  cand,
  input  logic          take,
  output logic          found,
  output logic [IW-1:0] idx
);
  logic [IW-1:0] last;
  int            slot;

  // walk from farthest to nearest so the nearest candidate wins
  always_comb begin
    found = 1'b0;
    idx   = '0;
    slot  = 0;
    for (int k = N; k >= 1; k--) begin
      slot = dws_pkg::rr_slot(int'(last), k, N);
      if (cand[slot]) begin
        found = 1'b1;
        idx   = IW'(slot);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             last <= IW'(N - 1);
    else if (take && found) last <= idx;
  end

  p_pick_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> cand[idx]);

endmodule

// File: rtl/dws_warp_ctx.sv
module dws_warp_ctx #(
  parameter int THREADS = 32,
  parameter int DEPTH   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               issue,
  input  logic [1:0]         op,
  input  logic [THREADS-1:0] cond,
  output logic [THREADS-1:0] active
);
  localparam int DW = $clog2(DEPTH + 1);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [THREADS-1:0] lane_stack [DEPTH];
  logic [DW-1:0]      depth;
  logic [THREADS-1:0] taken_lanes, other_lanes;
  logic [AW-1:0]      push_at, pop_at;
  logic               split;
  logic               is_branch, is_reconv, is_exit;

  assign taken_lanes = active & cond;
  assign other_lanes = active & ~cond;
  assign split       = (taken_lanes != '0) && (other_lanes != '0) && (depth < DW'(DEPTH));
  assign push_at     = AW'(depth);
  assign pop_at      = AW'(depth - 1'b1);
  assign is_branch   = issue && (op == 2'(dws_pkg::OP_BRANCH));
  assign is_reconv   = issue && (op == 2'(dws_pkg::OP_RECONV));
  assign is_exit     = issue && (op == 2'(dws_pkg::OP_EXIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= '1;
      depth  <= '0;
    end else if (is_branch) begin
      if (split) begin
        active <= taken_lanes;
        depth  <= depth + 1'b1;
      end
    end else if (is_reconv) begin
      if (depth != '0) begin
        active <= lane_stack[pop_at];
        depth  <= depth - 1'b1;
      end else begin
        active <= '1;
      end
    end else if (is_exit) begin
      active <= other_lanes;
    end
  end

  always_ff @(posedge clk) begin
    if (is_branch && split) lane_stack[push_at] <= other_lanes;
  end

  p_depth_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= DW'(DEPTH));
  p_split_push_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (is_branch && split) |=> (depth == $past(depth) + 1'b1));
  p_uniform_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (is_branch && !split) |=> $stable(active) && $stable(depth));
  p_reconv_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (is_reconv && depth == '0) |=> (&active));

endmodule

// File: rtl/warp_issue_dual.sv
module warp_issue_dual #(
  parameter int NUM_WARPS   = 8,
  parameter int THREADS     = 32,
  parameter int CORE_LANES  = 16,
  parameter int LDST_LANES  = 16,
  parameter int SFU_LANES   = 4,
  parameter int STACK_DEPTH = 4
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [NUM_WARPS-1:0]                 inst_valid,
  input  logic [NUM_WARPS-1:0][1:0]            inst_unit,
  input  logic [NUM_WARPS-1:0][1:0]            inst_op,
  input  logic [NUM_WARPS-1:0][THREADS-1:0]    inst_cond,
  output logic [NUM_WARPS-1:0]                 issue_ack,
  output logic [2:0]                           grp_issue,
  output logic [2:0][$clog2(NUM_WARPS)-1:0]    grp_warp,
  output logic [2:0][THREADS-1:0]              grp_mask,
  output logic [2:0]                           grp_busy
);
  localparam int WIDX = $clog2(NUM_WARPS);
  localparam int HALF = NUM_WARPS / 2;
  localparam int HIDX = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int NGRP = 3;

  logic [NUM_WARPS-1:0][THREADS-1:0] act;
  logic [NUM_WARPS-1:0]              ready;
  logic [1:0][HALF-1:0]              cand;
  logic [1:0]                        found, grant;
  logic [1:0][HIDX-1:0]              pick_idx;
  logic [1:0][WIDX-1:0]              sel_warp;
  logic [1:0][1:0]                   sel_unit;
  logic                              sched1_stall;
  logic [HALF-1:0]                   ack_even, ack_odd;

  // per-warp lane masks and divergence stacks
  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
    dws_warp_ctx #(.THREADS(THREADS), .DEPTH(STACK_DEPTH)) u_ctx (
      .clk(clk), .rst_n(rst_n), .issue(issue_ack[w]),
      .op(inst_op[w]), .cond(inst_cond[w]), .active(act[w]));
    assign ready[w] = inst_valid[w] && (act[w] != '0) &&
                      dws_pkg::unit_free(grp_busy, inst_unit[w]);
  end

  // occupancy timer per execution group
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam int LANES = (g == 0) ? CORE_LANES : (g == 1) ? LDST_LANES : SFU_LANES;
    dws_grp_timer #(.THREADS(THREADS), .LANES(LANES)) u_tmr (
      .clk(clk), .rst_n(rst_n), .start(grp_issue[g]), .busy(grp_busy[g]));

    p_issue_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      grp_issue[g] |-> !grp_busy[g]);
    p_mask_live_r10: assert property (@(posedge clk) disable iff (!rst_n)
      grp_issue[g] |-> (grp_mask[g] != '0));
  end

  // two schedulers: parity of the warp index selects the owner
  for (genvar s = 0; s < 2; s++) begin : g_sched
    for (genvar i = 0; i < HALF; i++) begin : g_cand
      assign cand[s][i] = ready[2*i + s];
    end
    dws_rr_pick #(.N(HALF), .IW(HIDX)) u_pick (
      .clk(clk), .rst_n(rst_n), .cand(cand[s]), .take(grant[s]),
      .found(found[s]), .idx(pick_idx[s]));
    assign sel_warp[s] = WIDX'(2 * int'(pick_idx[s]) + s);
    assign sel_unit[s] = inst_unit[sel_warp[s]];
  end

  // scheduler 0 has precedence on a shared group
  assign sched1_stall = found[0] && found[1] && (sel_unit[0] == sel_unit[1]);
  assign grant[0]     = found[0];
  assign grant[1]     = found[1] && !sched1_stall;

  always_comb begin
    for (int w = 0; w < NUM_WARPS; w++) begin
      issue_ack[w] = (grant[0] && sel_warp[0] == WIDX'(w)) ||
                     (grant[1] && sel_warp[1] == WIDX'(w));
    end
  end

  always_comb begin
    grp_issue = '0;
    grp_warp  = '0;
    grp_mask  = '0;
    for (int g = 0; g < NGRP; g++) begin
      if (grant[0] && sel_unit[0] == 2'(g)) begin
        grp_issue[g] = 1'b1;
        grp_warp[g]  = sel_warp[0];
        grp_mask[g]  = act[sel_warp[0]];
      end else if (grant[1] && sel_unit[1] == 2'(g)) begin
        grp_issue[g] = 1'b1;
        grp_warp[g]  = sel_warp[1];
        grp_mask[g]  = act[sel_warp[1]];
      end
    end
  end

  for (genvar i = 0; i < HALF; i++) begin : g_ackpar
    assign ack_even[i] = issue_ack[2*i];
    assign ack_odd[i]  = issue_ack[2*i + 1];
  end

  p_ack_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_ack & ~inst_valid) == '0);
  p_one_per_sched_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_even) && $onehot0(ack_odd));
  p_stall_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sched1_stall |-> (ack_odd == '0));
  p_rsvd_unit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(grp_issue) == $countones(issue_ack));

endmodule

// File: tb/tb_warp_issue_dual.sv
module tb_warp_issue_dual;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 8;
  localparam int T  = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NW-1:0]         inst_valid = '0;
  logic [NW-1:0][1:0]    inst_unit  = '0;
  logic [NW-1:0][1:0]    inst_op    = '0;
  logic [NW-1:0][T-1:0]  inst_cond  = '0;
  logic [NW-1:0]         issue_ack;
  logic [2:0]            grp_issue;
  logic [2:0][2:0]       grp_warp;
  logic [2:0][T-1:0]     grp_mask;
  logic [2:0]            grp_busy;

  warp_issue_dual dut (
    .clk(clk), .rst_n(rst_n), .inst_valid(inst_valid), .inst_unit(inst_unit),
    .inst_op(inst_op), .inst_cond(inst_cond), .issue_ack(issue_ack),
    .grp_issue(grp_issue), .grp_warp(grp_warp), .grp_mask(grp_mask),
    .grp_busy(grp_busy));

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int vectors = 0;
  int miscompares = 0;
  string cur_req = "R1";

  typedef struct {
    int         cyc;
    int         g;
    int         w;
    logic [T-1:0] m;
    string      tag;
  } exp_t;
  exp_t sb[$];

  // independent lane model: mask plus fixed-size stack per warp
  logic [T-1:0] m_mask [NW];
  logic [T-1:0] m_stk  [NW][4];
  int           m_sp   [NW];

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  task automatic model_apply(input int w, input int op, input logic [T-1:0] c);
    logic [T-1:0] tk, nt;
    tk = m_mask[w] & c;
    nt = m_mask[w] & ~c;
    case (op)
      1: if (tk != '0 && nt != '0 && m_sp[w] < 4) begin
           m_stk[w][m_sp[w]] = nt;
           m_sp[w]++;
           m_mask[w] = tk;
         end
      2: if (m_sp[w] > 0) begin
           m_sp[w]--;
           m_mask[w] = m_stk[w][m_sp[w]];
         end else m_mask[w] = '1;
      3: m_mask[w] = nt;
      default: ;
    endcase
  endtask

  task automatic expect_iss(input int g, input int w, input int op, input logic [T-1:0] c, input string tag);
    exp_t e;
    e.cyc = cyc; e.g = g; e.w = w; e.m = m_mask[w]; e.tag = tag;
    sb.push_back(e);
    model_apply(w, op, c);
  endtask

  task automatic drive(input int w, input int u, input int op, input logic [T-1:0] c);
    inst_valid[w] = 1'b1;
    inst_unit[w]  = 2'(u);
    inst_op[w]    = 2'(op);
    inst_cond[w]  = c;
  endtask

  task automatic drop(input int w);
    inst_valid[w] = 1'b0;
  endtask

  task automatic single(input int w, input int u, input int op, input logic [T-1:0] c, input string tag);
    @(negedge clk);
    drive(w, u, op, c);
    expect_iss(u, w, op, c, tag);
    @(negedge clk);
    drop(w);
  endtask

  // monitor: pops the scoreboard as issues appear
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      for (int g = 0; g < 3; g++) begin
        if (grp_issue[g]) begin
          if (sb.size() == 0 || sb[0].cyc != cyc || sb[0].g != g) begin
            vectors++;
            miscompares++;
            $display("FAIL %s unexpected issue group %0d actual=warp %0d expected=none", cur_req, g, grp_warp[g]);
          end else begin
            e = sb.pop_front();
            check(grp_warp[g] == 3'(e.w) && grp_mask[g] == e.m, e.tag,
                  {29'd0, grp_warp[g], grp_mask[g]}, {29'd0, 3'(e.w), e.m});
          end
        end
      end
      while (sb.size() > 0 && sb[0].cyc <= cyc) begin
        e = sb.pop_front();
        vectors++;
        miscompares++;
        $display("FAIL %s missing issue actual=none expected=group %0d warp %0d", e.tag, e.g, e.w);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  localparam int EV_ORDER [4] = '{4, 6, 0, 2};
  localparam int OD_ORDER [4] = '{5, 7, 1, 3};

  initial begin
    for (int w = 0; w < NW; w++) begin
      m_mask[w] = '1;
      m_sp[w] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: idle after reset
    @(negedge clk); #1;
    check(grp_busy == 3'b000, "R1 groups idle", 64'(grp_busy), 64'd0);
    check(issue_ack == '0, "R1 no ack", 64'(issue_ack), 64'd0);

    // R2 / R6: one issue per scheduler, routed by unit code, full mask (R1)
    cur_req = "R2";
    @(negedge clk);
    drive(0, 0, 0, '0); drive(1, 1, 0, '0);
    expect_iss(0, 0, 0, '0, "R2 R6 R1 warp0 core full mask");
    expect_iss(1, 1, 0, '0, "R2 R6 warp1 load/store");
    #1 check(issue_ack == 8'h03, "R2 acks", 64'(issue_ack), 64'h03);
    @(negedge clk);
    drop(0); drop(1);
    #1 check(grp_busy == 3'b011, "R3 busy after issue", 64'(grp_busy), 64'h3);
    @(negedge clk);
    #1 check(grp_busy == 3'b000, "R3 free after two cycles", 64'(grp_busy), 64'h0);

    // R3: 16-wide group blocks the next cycle
    cur_req = "R3";
    @(negedge clk);
    drive(2, 0, 0, '0); expect_iss(0, 2, 0, '0, "R3 warp2 core");
    @(negedge clk);
    drop(2); drive(4, 0, 0, '0);
    #1 check(issue_ack == '0, "R3 busy core blocks", 64'(issue_ack), 64'd0);
    @(negedge clk);
    expect_iss(0, 4, 0, '0, "R3 core accepts after 2 cycles");
    #1 check(issue_ack == 8'h10, "R3 ack warp4", 64'(issue_ack), 64'h10);
    @(negedge clk);
    drop(4);

    // R3: 4-wide group held 8 cycles
    @(negedge clk);
    drive(6, 2, 0, '0); expect_iss(2, 6, 0, '0, "R3 warp6 special");
    @(negedge clk);
    drop(6); drive(3, 2, 0, '0);
    for (int k = 1; k < 8; k++) begin
      #1 check(grp_busy[2] && issue_ack == '0, "R3 special busy", {grp_busy[2], issue_ack}, {1'b1, 8'h00});
      @(negedge clk);
    end
    expect_iss(2, 3, 0, '0, "R3 special accepts after 8 cycles");
    #1 check(issue_ack == 8'h08, "R3 ack warp3", 64'(issue_ack), 64'h08);
    @(negedge clk);
    drop(3);

    // R5: contention on the core group
    cur_req = "R5";
    @(negedge clk);
    drive(0, 0, 0, '0); drive(1, 0, 0, '0);
    expect_iss(0, 0, 0, '0, "R5 scheduler 0 wins");
    #1 check(issue_ack == 8'h01, "R5 scheduler 1 stalls", 64'(issue_ack), 64'h01);
    @(negedge clk);
    drop(0); drop(1);
    @(negedge clk);
    drive(2, 0, 0, '0); drive(1, 0, 0, '0); drive(3, 1, 0, '0);
    expect_iss(0, 2, 0, '0, "R5 scheduler 0 warp2");
    #1 check(issue_ack == 8'h04, "R5 stall despite free load/store", 64'(issue_ack), 64'h04);
    @(negedge clk);
    drop(2); drop(1); drop(3);

    // R4: round-robin, scheduler 0 on the core group
    cur_req = "R4";
    @(negedge clk);
    for (int i = 0; i < 4; i++) drive(2*i, 0, 0, '0);
    for (int i = 0; i < 4; i++) begin
      expect_iss(0, EV_ORDER[i], 0, '0, "R4 even rotation");
      @(negedge clk);
      drop(EV_ORDER[i]);
      @(negedge clk);
    end
    // R4: round-robin, scheduler 1 on the load/store group
    for (int i = 0; i < 4; i++) drive(2*i + 1, 1, 0, '0);
    for (int i = 0; i < 4; i++) begin
      expect_iss(1, OD_ORDER[i], 0, '0, "R4 odd rotation");
      @(negedge clk);
      drop(OD_ORDER[i]);
      if (i < 3) @(negedge clk);
    end

    // R7 / R9: divergence then reconvergence
    cur_req = "R7";
    single(2, 0, 1, 32'h0000FFFF, "R7 branch issues full mask");
    single(2, 0, 0, '0, "R7 taken lanes run first");
    single(2, 0, 2, '0, "R9 reconverge issues taken mask");
    single(2, 0, 0, '0, "R9 not-taken lanes after pop");
    single(2, 0, 2, '0, "R9 reconverge on empty stack");
    single(2, 0, 0, '0, "R9 full mask restored");

    // R8: uniform branches
    cur_req = "R8";
    single(4, 0, 1, '1, "R8 all-ones branch");
    single(4, 0, 0, '0, "R8 mask unchanged after all-ones");
    single(4, 0, 1, '0, "R8 all-zeros branch");
    single(4, 0, 0, '0, "R8 mask unchanged after all-zeros");
    single(6, 0, 1, 32'h00FF00FF, "R7 outer split");
    single(6, 0, 1, 32'hFF00FF00, "R8 uniform over active lanes");
    single(6, 0, 0, '0, "R8 no split inside");
    single(6, 0, 2, '0, "R9 pop after uniform");
    single(6, 0, 0, '0, "R9 saved lanes restored");
    single(6, 0, 2, '0, "R9 second reconverge");
    single(6, 0, 0, '0, "R9 full after empty pop");

    // R10: exit and skipped warp
    cur_req = "R10";
    single(3, 1, 3, 32'h0000000F, "R10 exit issues live mask");
    single(3, 1, 0, '0, "R10 exited lanes cleared");
    single(5, 1, 3, '1, "R10 full exit");
    @(negedge clk);
    drive(5, 1, 0, '0);
    for (int k = 0; k < 3; k++) begin
      #1 check(issue_ack == '0 && grp_issue == '0, "R10 empty warp skipped",
               {grp_issue, issue_ack}, 64'd0);
      @(negedge clk);
    end
    drop(5);

    // R11: reserved unit code
    cur_req = "R11";
    @(negedge clk);
    drive(0, 3, 0, '0);
    for (int k = 0; k < 2; k++) begin
      #1 check(issue_ack == '0 && grp_issue == '0, "R11 reserved unit not issued",
               {grp_issue, issue_ack}, 64'd0);
      @(negedge clk);
    end
    drop(0);

    repeat (10) @(negedge clk);
    check(sb.size() == 0, "R6 scoreboard drained", 64'(sb.size()), 64'd0);
    summary();
  end

endmodule